// File: doc/BRIEF.md
# Four-Channel Bit-Interleaved Serial Multiplexer

This block takes the receive octets and the four per-timeslot signaling bits of four 2.048 Mbit/s channels and merges them into a single 16.384 Mbit/s serial stream, one output bit per clock. Bits are interleaved across the channels: every output group carries the same bit position for channel 0, then channel 1, then channel 2, then channel 3. Each timeslot takes 64 clocks. Payload positions 1 to 4, counted from the MSB, are each sent as two identical four-channel groups. Each of payload positions 5 to 8 is followed by a four-channel group of its signaling bit (A, B, C, D in turn), and that group replaces the repeated payload group.

A frame holds 32 timeslots, which is 2048 clocks. A two-cycle frame sync pulse marks the frame boundary. The second high cycle is position 0 of the new frame, and the serial output is quiet until the first such pulse after reset. The block drives out the index of the current timeslot. Upstream logic uses it to place the next timeslot's octets and signaling bits on the parallel inputs, and these are captured at the first clock of each timeslot.

Top module: `bitlane_mux`

## Requirements
- R1: While `rst` is high, `ser_o` and `slot_o` are 0.
- R2: When `fsync_i` is sampled high on two consecutive clock edges, the second edge loads position 0 of a frame. After that edge `slot_o` is 0, and `ser_o` carries bit 7 of channel 0's octet (channel c's octet is `octets_i[8c+7:8c]`), taken from the inputs present at that edge.
- R3: Within a timeslot, output position k (0..63) carries channel k mod 4. For payload positions p = floor(k/8) from 0 to 3, both four-bit groups (k mod 8 below 4, and 4 or above) carry octet bit 7-p.
- R4: For p = 4..7, the group with k mod 8 below 4 carries octet bit 7-p. The group with k mod 8 of 4 or above carries signaling bit A, B, C or D (p = 4, 5, 6, 7). Channel c's signaling nibble is `sigs_i[4c+3:4c]`, with A at bit 3 and D at bit 0.
- R5: The octets and signaling bits are captured only at position 0 of each timeslot. Changes at any other position do not affect the output.
- R6: After reset, `ser_o` stays 0 until the first two-cycle sync has been seen.
- R7: `slot_o` advances by one every 64 clocks. With no sync, it wraps from 31 to 0 after 2048 clocks.
- R8: A two-cycle sync arriving in the middle of a frame restarts the frame at position 0 at its second cycle.
- R9: A single-cycle high pulse on `fsync_i` neither starts nor realigns a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one output bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync_i | input | 1 | Frame sync, high for two cycles around the frame boundary |
| octets_i | input | 32 | Octets of channels 0..3, channel c at bits 8c+7..8c |
| sigs_i | input | 16 | Signaling nibbles, channel c at bits 4c+3..4c (A = MSB) |
| ser_o | output | 1 | Multiplexed serial output |
| slot_o | output | 5 | Timeslot of the bit currently on `ser_o` |

## Verification
The hardest conditions to reach from the ports are the ones that depend on a sync pulse's length and timing: an isolated one-cycle pulse that must be ignored, and a valid pulse that lands in the middle of a running frame. The stimulus produces both on purpose. It first sends a lone pulse before any alignment, so a wrong start shows up as the output leaving its quiet state. It then sends a two-cycle pulse several slots into a frame. The mid-slot capture rule is covered by changing the parallel inputs every clock, so any read outside the capture point shows up as a bit mismatch.

// File: rtl/bitlane_mux_pkg.sv
package bitlane_mux_pkg;
  localparam int OCT_BITS = 8;
  localparam int SIG_BITS = 4;
  localparam int POS_BITS = 3;
endpackage

// File: rtl/blm_timing.sv
module blm_timing
  import bitlane_mux_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOTS  = 32,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PER_W  = CH_W + POS_BITS + 1,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int POS_W  = PER_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync_i,
  output logic [POS_W-1:0]  pos_next_o,
  output logic              load_o,
  output logic              lock_next_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int LAST = SLOTS * (1 << PER_W) - 1;

  logic             sync_d_q;
  logic             lock_q;
  logic [POS_W-1:0] pos_q;
  logic             start_w;

  assign start_w     = fsync_i & sync_d_q;
  assign lock_next_o = lock_q | start_w;

  always_comb begin
    if (start_w)                    pos_next_o = '0;
    else if (pos_q == POS_W'(LAST)) pos_next_o = '0;
    else                            pos_next_o = pos_q + POS_W'(1);
  end

  assign load_o = (pos_next_o[PER_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_d_q <= 1'b0;
      lock_q   <= 1'b0;
      pos_q    <= '0;
      slot_o   <= '0;
    end else begin
      sync_d_q <= fsync_i;
      lock_q   <= lock_next_o;
      pos_q    <= pos_next_o;
      slot_o   <= pos_next_o[POS_W-1:PER_W];
    end
  end

  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (fsync_i && $past(fsync_i) && !$past(rst)) |=> (slot_o == '0));

  p_slot_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!start_w && (pos_q[PER_W-1:0] != '1)) |=> $stable(slot_o));

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (!start_w && pos_q == POS_W'(LAST)) |=> (slot_o == '0));

  p_lone_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (fsync_i && !sync_d_q && !lock_q) |=> !lock_q);
endmodule

// File: rtl/blm_select.sv
module blm_select
  import bitlane_mux_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int PER_W = CH_W + POS_BITS + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_i,
  input  logic [PER_W-1:0]             pos_i,
  input  logic [NUM_CH*OCT_BITS-1:0]   oct_i,
  input  logic [NUM_CH*SIG_BITS-1:0]   sig_i,
  output logic                         bit_o
);
  logic [NUM_CH*OCT_BITS-1:0] oct_q, oct_src;
  logic [NUM_CH*SIG_BITS-1:0] sig_q, sig_src;
  logic [CH_W-1:0]            ch;
  logic                       half;
  logic [POS_BITS-1:0]        bp;
  logic [OCT_BITS-1:0]        oct_lane;
  logic [SIG_BITS-1:0]        sig_lane;

  assign oct_src = load_i ? oct_i : oct_q;
  assign sig_src = load_i ? sig_i : sig_q;

  assign ch   = pos_i[CH_W-1:0];
  assign half = pos_i[CH_W];
  assign bp   = pos_i[PER_W-1 -: POS_BITS];

  assign oct_lane = oct_src[OCT_BITS*int'(ch) +: OCT_BITS];
  assign sig_lane = sig_src[SIG_BITS*int'(ch) +: SIG_BITS];

  always_comb begin
    if (!bp[2] || !half) bit_o = oct_lane[~bp];
    else                 bit_o = sig_lane[~bp[1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oct_q <= '0;
      sig_q <= '0;
    end else if (load_i) begin
      oct_q <= oct_i;
      sig_q <= sig_i;
    end
  end

  p_capture_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(oct_q) && $stable(sig_q)));
endmodule

// File: rtl/bitlane_mux.sv
module bitlane_mux
  import bitlane_mux_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SLOTS  = 32,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PER_W  = CH_W + POS_BITS + 1,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int POS_W  = PER_W + SLOT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fsync_i,
  input  logic [NUM_CH*OCT_BITS-1:0] octets_i,
  input  logic [NUM_CH*SIG_BITS-1:0] sigs_i,
  output logic                       ser_o,
  output logic [SLOT_W-1:0]          slot_o
);
  logic [POS_W-1:0] pos_next;
  logic             load;
  logic             lock_next;
  logic             bit_w;

  blm_timing #(.NUM_CH(NUM_CH), .SLOTS(SLOTS)) timing_i (
    .clk(clk), .rst(rst), .fsync_i(fsync_i),
    .pos_next_o(pos_next), .load_o(load),
    .lock_next_o(lock_next), .slot_o(slot_o)
  );

  blm_select #(.NUM_CH(NUM_CH)) select_i (
    .clk(clk), .rst(rst), .load_i(load),
    .pos_i(pos_next[PER_W-1:0]),
    .oct_i(octets_i), .sig_i(sigs_i), .bit_o(bit_w)
  );

  always_ff @(posedge clk) begin
    if (rst) ser_o <= 1'b0;
    else     ser_o <= lock_next ? bit_w : 1'b0;
  end

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !lock_next |=> !ser_o);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (rst -> (!ser_o && slot_o == '0)));
endmodule

// File: tb/bitlane_mux_tb_top.sv
`timescale 1ns/1ps
module bitlane_mux_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fsync_i = 1'b0;
  logic [31:0] octets_i = '0;
  logic [15:0] sigs_i = '0;
  logic        ser_o;
  logic [4:0]  slot_o;

  always #2.5 clk = ~clk;

  bitlane_mux dut_i (
    .clk(clk), .rst(rst), .fsync_i(fsync_i),
    .octets_i(octets_i), .sigs_i(sigs_i),
    .ser_o(ser_o), .slot_o(slot_o)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  string req    = "R1";

  // behavioural reference
  int   m_pos = 0;
  bit   m_prev = 0, m_lock = 0;
  int   m_oct[4];
  int   m_sig[4];
  logic exp_ser = 0;
  int   exp_slot = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_prev = 0; m_lock = 0; exp_ser = 0; exp_slot = 0;
      for (int c = 0; c < 4; c++) begin m_oct[c] = 0; m_sig[c] = 0; end
    end else begin
      int k, bp, grp, ch;
      bit start;
      start = fsync_i && m_prev;
      m_pos = start ? 0 : (m_pos + 1) % 2048;
      if (start) m_lock = 1;
      if (m_pos % 64 == 0)
        for (int c = 0; c < 4; c++) begin
          m_oct[c] = int'(octets_i[c*8 +: 8]);
          m_sig[c] = int'(sigs_i[c*4 +: 4]);
        end
      k = m_pos % 64; bp = k / 8; grp = (k / 4) % 2; ch = k % 4;
      if (bp < 4 || grp == 0) exp_ser = m_oct[ch][7 - bp];
      else                    exp_ser = m_sig[ch][3 - (bp - 4)];
      if (!m_lock) exp_ser = 0;
      exp_slot = m_pos / 64;
      m_prev = fsync_i;
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic check(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!rst && !done) begin
      checks++;
      if (ser_o !== exp_ser || int'(slot_o) != exp_slot) begin
        fails++;
        $display("FAIL %s: actual ser_o=%0b slot_o=%0d expected ser_o=%0b slot_o=%0d",
                 req, ser_o, slot_o, exp_ser, exp_slot);
      end
    end
  endtask

  task automatic rand_data();
    octets_i = $urandom;
    sigs_i   = 16'($urandom);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
      $finish;
    end
  end

  initial begin
    int highs, wraps, prev_slot, bad_steps;
    // R1: reset state
    rand_data();
    repeat (4) @(negedge clk);
    check("R1", int'(ser_o), 0, "ser_o in reset");
    check("R1", int'(slot_o), 0, "slot_o in reset");
    rst = 1'b0;

    // R6: quiet before any sync
    req = "R6"; highs = 0;
    repeat (100) begin rand_data(); step(); highs += int'(ser_o); end
    check("R6", highs, 0, "high bits before sync");

    // R9: lone pulse is ignored
    req = "R9"; highs = 0;
    fsync_i = 1'b1; step(); fsync_i = 1'b0;
    repeat (60) begin rand_data(); step(); highs += int'(ser_o); end
    check("R9", highs, 0, "high bits after single-cycle pulse");

    // R2: two-cycle sync starts frame
    req = "R2";
    octets_i = 32'h5A3C_0F81; sigs_i = 16'h1234;
    fsync_i = 1'b1; step(); step(); fsync_i = 1'b0;
    check("R2", int'(slot_o), 0, "slot_o after sync");
    check("R2", int'(ser_o), 1, "ch0 MSB at position 0");

    // R3 R4: fixed data patterns across whole slots
    req = "R3 R4";
    octets_i = 32'hFFFF_FFFF; sigs_i = 16'h0000;
    repeat (512) step();
    octets_i = 32'h0000_0000; sigs_i = 16'hFFFF;
    repeat (512) step();
    octets_i = 32'h8040_2001; sigs_i = 16'h8421;
    repeat (512) step();
    octets_i = 32'hA5C3_3C5A; sigs_i = 16'h69C3;
    repeat (512) step();

    // R5: inputs changing every clock, only slot-start values count
    req = "R5";
    repeat (1024) begin rand_data(); step(); end

    // R7: free run through a frame wrap
    req = "R7"; wraps = 0; bad_steps = 0;
    rand_data();
    prev_slot = int'(slot_o);
    repeat (2200) begin
      step();
      if (int'(slot_o) != prev_slot) begin
        if (prev_slot == 31 && slot_o == 5'd0) wraps++;
        else if (int'(slot_o) != prev_slot + 1) bad_steps++;
      end
      prev_slot = int'(slot_o);
    end
    check("R7", int'(wraps > 0), 1, "wrap 31 to 0 seen");
    check("R7", bad_steps, 0, "non-unit slot steps");

    // R8: mid-frame realignment
    req = "R8";
    repeat (333) begin rand_data(); step(); end
    octets_i = 32'h0000_0001; sigs_i = 16'h0;
    fsync_i = 1'b1; step(); step(); fsync_i = 1'b0;
    check("R8", int'(slot_o), 0, "slot_o after mid-frame sync");
    check("R8", int'(ser_o), 0, "ch0 MSB after realign");
    repeat (300) begin rand_data(); step(); end

    // R9 again while aligned: lone pulse must not realign
    req = "R9";
    repeat (10) step();
    prev_slot = int'(slot_o);
    fsync_i = 1'b1; step(); fsync_i = 1'b0;
    repeat (64) step();
    check("R9", int'(slot_o), (prev_slot + 1) % 32, "slot after lone pulse");

    done = 1;
    report();
    $finish;
  end
endmodule